// File: doc/BRIEF.md
# Ethernet PHY Management Register File

This block provides the management register space of a simple Ethernet transceiver model. It holds 32 registers of 16 bits each. A serial management front end, which is not part of this block, sends it register numbers, write data and write strobes through a parallel port. Most registers are plain storage. Three of them are not read from storage: the status word, the partner-ability word and the vendor diagnostics word. These are built on every read from the live link input and from the stored advertisement register (number 4). As a result, the modelled link always appears to have negotiated whatever the local side advertises.

The request input is wider than needed, and only its low five bits pick a register. Reads are combinational, so the read word follows the request in the same cycle. Writes take effect on the rising clock edge while the write strobe is high. A write to one of the three computed registers goes into storage, but it never changes what a read of that register returns.

Top module: `pm_phy_regs`

## Requirements
- R1: After reset, register 0 reads 0x3100, register 2 reads 0x0300, register 3 reads 0xE400, register 4 reads 0x01E1, and every other plain register reads 0x0000.
- R2: Register 1 reads 0x782C (bits 14, 13, 12, 11, 5, 3 and 2 set) while `link_up` is 1, and reads 0x0000 while `link_up` is 0.
- R3: Register 5 reads 0x4001 OR'ed with bits 8:5 of register 4. No other bits are set, and the value does not depend on `link_up`.
- R4: While `link_up` is 1, register 18 reads bit 10 = reg4[7] OR reg4[8] and bit 11 = reg4[8] OR reg4[6], with all other bits 0. While `link_up` is 0 it reads 0x0000.
- R5: Every register other than 1, 5 and 18 reads back the last word written to it.
- R6: Only `req[4:0]` selects the register. The upper request bits have no effect on reads or writes.
- R7: `rd_data` follows `req` in the same cycle. A write becomes visible only after the rising edge at which `wr_en` is sampled high.
- R8: A change of `link_up` shows on the reads of registers 1 and 18 in the same cycle, without waiting for a clock edge.
- R9: A write to register 1, 5 or 18 does not change the value a read of that register returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes happen on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | REQ_W (8) | Register request; the low 5 bits select the register |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| link_up | input | 1 | Live link state |
| rd_data | output | 16 | Combinational read data |

## Verification
Read data is combinational, so a fault in storage shows at `rd_data` as soon as the bad entry is selected. A wrong reset constant shows at the first read after reset. A write landing in the wrong entry shows on the cycle after the write edge, when the intended register is read back. A fault in the computed paths shows only under the matching advertisement bits or link state. The bench therefore walks register 4 through patterns that each set a single relevant bit, and toggles the link in the middle of a cycle.

// File: rtl/pm_phy_pkg.sv
package pm_phy_pkg;
    localparam int DATA_W   = 16;
    localparam int REG_CNT  = 32;
    localparam int SEL_W    = $clog2(REG_CNT);

    localparam logic [SEL_W-1:0] SEL_CTRL = 5'd0;
    localparam logic [SEL_W-1:0] SEL_STAT = 5'd1;
    localparam logic [SEL_W-1:0] SEL_IDH  = 5'd2;
    localparam logic [SEL_W-1:0] SEL_IDL  = 5'd3;
    localparam logic [SEL_W-1:0] SEL_ADV  = 5'd4;
    localparam logic [SEL_W-1:0] SEL_LPA  = 5'd5;
    localparam logic [SEL_W-1:0] SEL_DIAG = 5'd18;

    localparam logic [DATA_W-1:0] STAT_LINKED = 16'h782C;
    localparam logic [DATA_W-1:0] LPA_FIXED   = 16'h4001;
    localparam logic [DATA_W-1:0] LPA_ADV_MSK = 16'h01E0;

    function automatic logic [DATA_W-1:0] pm_reset_word(input int idx);
        case (idx)
            0:       return 16'h3100;
            2:       return 16'h0300;
            3:       return 16'hE400;
            4:       return 16'h01E1;
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/pm_reg_store.sv
module pm_reg_store
    import pm_phy_pkg::*;
#(
    parameter int DEPTH = REG_CNT,
    parameter int DW    = DATA_W,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] sel,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] stored_word,
    output logic [DW-1:0] adv_word
);
    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= pm_reset_word(i);
            end
        end else if (wr_en) begin
            cells[sel] <= wr_data;
        end
    end

    assign stored_word = cells[sel];
    assign adv_word    = cells[SEL_ADV];
endmodule

// File: rtl/pm_view_gen.sv
module pm_view_gen
    import pm_phy_pkg::*;
(
    input  logic [SEL_W-1:0]  sel,
    input  logic              link_up,
    input  logic [DATA_W-1:0] stored_word,
    input  logic [DATA_W-1:0] adv_word,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] diag_word;
    logic [DATA_W-1:0] lpa_word;

    always_comb begin
        diag_word     = '0;
        diag_word[10] = adv_word[7] | adv_word[8];
        diag_word[11] = adv_word[8] | adv_word[6];
        lpa_word      = LPA_FIXED | (adv_word & LPA_ADV_MSK);
    end

    always_comb begin
        case (sel)
            SEL_STAT: rd_data = link_up ? STAT_LINKED : '0;
            SEL_LPA:  rd_data = lpa_word;
            SEL_DIAG: rd_data = link_up ? diag_word : '0;
            default:  rd_data = stored_word;
        endcase
    end
endmodule

// File: rtl/pm_phy_regs.sv
module pm_phy_regs
    import pm_phy_pkg::*;
#(
    parameter int REQ_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REQ_W-1:0]  req,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              link_up,
    output logic [DATA_W-1:0] rd_data
);
    logic [SEL_W-1:0]  sel;
    logic [DATA_W-1:0] stored_word;
    logic [DATA_W-1:0] adv_word;
    logic              unused_req_hi;

    assign sel           = req[SEL_W-1:0];
    assign unused_req_hi = ^req[REQ_W-1:SEL_W];

    pm_reg_store #(.DEPTH(REG_CNT), .DW(DATA_W)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel         (sel),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .stored_word (stored_word),
        .adv_word    (adv_word)
    );

    pm_view_gen u_view (
        .sel         (sel),
        .link_up     (link_up),
        .stored_word (stored_word),
        .adv_word    (adv_word),
        .rd_data     (rd_data)
    );
endmodule

// File: rtl/pm_phy_regs_chk.sv
module pm_phy_regs_chk
    import pm_phy_pkg::*;
#(
    parameter int REQ_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [REQ_W-1:0]  req,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              link_up,
    input logic [DATA_W-1:0] rd_data
);
    logic [SEL_W-1:0] s;
    logic             plain_sel;
    assign s         = req[SEL_W-1:0];
    assign plain_sel = (s != SEL_STAT) && (s != SEL_LPA) && (s != SEL_DIAG);

    // R1
    ctrl_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n) && s == SEL_CTRL) |-> rd_data == 16'h3100);

    // R2
    stat_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s == SEL_STAT && !link_up) |-> rd_data == 16'h0000);

    // R8
    stat_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s == SEL_STAT && link_up) |-> rd_data == 16'h782C);

    // R3
    lpa_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s == SEL_LPA) |-> (rd_data[14] && rd_data[0] && (rd_data & 16'hBE1E) == 16'h0000));

    // R4
    diag_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s == SEL_DIAG && !link_up) |-> rd_data == 16'h0000);

    // R5
    write_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && plain_sel) |=> (!$stable(s) || wr_en || rd_data == $past(wr_data)));
endmodule

bind pm_phy_regs pm_phy_regs_chk #(.REQ_W(REQ_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .link_up (link_up),
    .rd_data (rd_data)
);

// File: tb/sim_pm_phy_regs.sv
module sim_pm_phy_regs;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [7:0]  req = '0;
    logic        wr_en = 0;
    logic [15:0] wr_data = '0;
    logic        link_up = 1;
    logic [15:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    pm_phy_regs #(.REQ_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .wr_en(wr_en),
        .wr_data(wr_data), .link_up(link_up), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        req = a; wr_data = d; wr_en = 1;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [15:0] exp);
        @(negedge clk);
        req = a;
        #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic t_reset();
        rd_chk("R1 reg0", 8'd0, 16'h3100);
        rd_chk("R1 reg2", 8'd2, 16'h0300);
        rd_chk("R1 reg3", 8'd3, 16'hE400);
        rd_chk("R1 reg4", 8'd4, 16'h01E1);
        rd_chk("R1 reg9", 8'd9, 16'h0000);
        rd_chk("R3 lpa default", 8'd5, 16'h41E1);
        rd_chk("R4 diag default", 8'd18, 16'h0C00);
    endtask

    task automatic t_status();
        link_up = 1;
        rd_chk("R2 stat up", 8'd1, 16'h782C);
        link_up = 0;
        rd_chk("R2 stat down", 8'd1, 16'h0000);
        link_up = 1;
    endtask

    task automatic t_adv_patterns();
        wr(8'd4, 16'h0040);
        rd_chk("R3 lpa adv6", 8'd5, 16'h4041);
        rd_chk("R4 diag adv6", 8'd18, 16'h0800);
        wr(8'd4, 16'h0080);
        rd_chk("R3 lpa adv7", 8'd5, 16'h4081);
        rd_chk("R4 diag adv7", 8'd18, 16'h0400);
        wr(8'd4, 16'h0100);
        rd_chk("R4 diag adv8", 8'd18, 16'h0C00);
        wr(8'd4, 16'hFE1F);
        rd_chk("R3 lpa no adv", 8'd5, 16'h4001);
        rd_chk("R4 diag no adv", 8'd18, 16'h0000);
        link_up = 0;
        wr(8'd4, 16'h01E0);
        rd_chk("R3 lpa link down", 8'd5, 16'h41E1);
        rd_chk("R4 diag link down", 8'd18, 16'h0000);
        link_up = 1;
    endtask

    task automatic t_plain();
        wr(8'd7, 16'hA5C3);
        wr(8'd31, 16'h1234);
        wr(8'd0, 16'h8000);
        rd_chk("R5 reg7", 8'd7, 16'hA5C3);
        rd_chk("R5 reg31", 8'd31, 16'h1234);
        rd_chk("R5 reg0", 8'd0, 16'h8000);
        rd_chk("R5 reg6 untouched", 8'd6, 16'h0000);
    endtask

    task automatic t_alias();
        wr(8'hE9, 16'h5A5A);
        rd_chk("R6 write via hi bits", 8'h09, 16'h5A5A);
        rd_chk("R6 read via hi bits", 8'h67, 16'hA5C3);
        rd_chk("R6 reg1 via hi bits", 8'h21, 16'h782C);
    endtask

    task automatic t_timing();
        @(negedge clk);
        req = 8'd10; wr_data = 16'hBEEF; wr_en = 1;
        #1;
        chk("R7 before edge", rd_data, 16'h0000);
        @(posedge clk);
        #1;
        chk("R7 after edge", rd_data, 16'hBEEF);
        @(negedge clk);
        wr_en = 0;
        req = 8'd7;
        #1;
        chk("R7 same-cycle read", rd_data, 16'hA5C3);
    endtask

    task automatic t_link_live();
        @(negedge clk);
        req = 8'd1;
        link_up = 1;
        #1;
        chk("R8 stat up", rd_data, 16'h782C);
        #2;
        link_up = 0;
        #1;
        chk("R8 stat falls mid-cycle", rd_data, 16'h0000);
        req = 8'd18;
        wr(8'd4, 16'h0100);
        req = 8'd18;
        #1;
        chk("R8 diag while down", rd_data, 16'h0000);
        link_up = 1;
        #1;
        chk("R8 diag rises mid-cycle", rd_data, 16'h0C00);
    endtask

    task automatic t_computed_write();
        wr(8'd1, 16'h0000);
        rd_chk("R9 reg1 write ignored", 8'd1, 16'h782C);
        wr(8'd5, 16'hFFFF);
        rd_chk("R9 reg5 write ignored", 8'd5, 16'h4101);
        wr(8'd18, 16'hFFFF);
        rd_chk("R9 reg18 write ignored", 8'd18, 16'h0C00);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_status();
        t_adv_patterns();
        t_plain();
        t_alias();
        t_timing();
        t_link_live();
        t_computed_write();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule